// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

The block links two parallel data ports, A and B, and can move data across in either direction. Each direction has its own storage register, its own capture strobe, its own source select and its own output enable. The select picks what goes out on the destination port. It is either the live value currently on the opposite port or the value held in that direction's register. Each port is split into an input, an output and an output-enable, so an outer pad wrapper can build the tristate bus. The block itself stays purely synchronous.

The A-to-B enable is active high and the B-to-A enable is active low. Both paths switched off isolate the two ports. Both registers sample their own port's resolved value on any clock edge where their capture strobe is high, whatever the selects and enables are doing. The resolved value is the driven value when the transceiver drives that port, and the external input data otherwise. This lets one port's data be loaded into both registers. When both directions drive in live mode, the pair forms a self-holding loop, and each port keeps the last value it resolved to. The width is a parameter (default 8), and every bit has the same logic.

Top module: `bus_xcvr`

## Requirements
- R1: Port B is driven (`b_oe`=1) exactly when `ab_en`=1. Port A is driven (`a_oe`=1) exactly when `ba_en_n`=0.
- R2: With `ab_en`=0 and `ba_en_n`=1, neither port is driven, and both `a_out` and `b_out` read zero.
- R3: A select at 0 routes live data. `b_out` follows `a_in` in the same cycle when A is not driven, and `a_out` follows `b_in` when B is not driven.
- R4: A select at 1 routes stored data. `b_out` equals the A-side register and `a_out` equals the B-side register.
- R5: On a clock edge with `cap_a`=1, the A-side register loads the resolved value of port A. Selects and enables have no effect on this.
- R6: `cap_a` and `cap_b` may be high in the same cycle, and each register then loads its own port independently.
- R7: While a port is driven, its register captures the driven value. Data live on A, passed to B and captured by `cap_b`, therefore lands in the B-side register.
- R8: With both directions enabled and both selects at 0, each port is driven with the value it resolved to on the previous cycle. The value holds while the mode lasts, and the external inputs have no effect on it.
- R9: When the live and stored sources are equal, toggling a select leaves the driven output unchanged.
- R10: Asserting `rst_n` low clears both storage registers and both hold values to zero.
- R11: With its capture strobe at 0, a register keeps its contents whatever its port does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ab_en | input | 1 | A-to-B output enable, active high |
| ba_en_n | input | 1 | B-to-A output enable, active low |
| ab_sel | input | 1 | A-to-B source: 0 live A, 1 stored A |
| ba_sel | input | 1 | B-to-A source: 0 live B, 1 stored B |
| cap_a | input | 1 | Load A-side register at this edge |
| cap_b | input | 1 | Load B-side register at this edge |
| a_in | input | WIDTH | External data on port A |
| a_out | output | WIDTH | Data driven onto port A |
| a_oe | output | 1 | Port A output enable |
| b_in | input | WIDTH | External data on port B |
| b_out | output | WIDTH | Data driven onto port B |
| b_oe | output | 1 | Port B output enable |

## Verification
Capture and drive can fall in the same cycle. A register can load its own port while the opposite direction drives that port, so the loaded value must be the driven one and not the external input. The bench provokes this by enabling live A-to-B transfer while strobing `cap_b` with a different value on `b_in`, and by strobing both captures together during stored and loop modes. A behavioural reference model, compared on every clock, judges the result. A random sweep over all sixteen enable and select combinations, with random captures, exposes further collisions.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic [1:0] {
    LIVE_PORT    = 2'd0,
    LIVE_PEERREG = 2'd1,
    LIVE_HOLD    = 2'd2
  } live_src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (load) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/xcvr_gfmux.sv
module xcvr_gfmux #(
  parameter int WIDTH = 8
) (
  input  logic             sel,
  input  logic [WIDTH-1:0] live,
  input  logic [WIDTH-1:0] stored,
  output logic [WIDTH-1:0] y
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      y[i] = (live[i] & ~sel) | (stored[i] & sel) | (live[i] & stored[i]);
    end
  end

  always_comb begin
    if (live == stored) begin
      a_r9_consensus: assert (y == live);
    end
  end
endmodule

// File: rtl/xcvr_leg.sv
module xcvr_leg
  import xcvr_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             drv_here,
  input  logic             drv_there,
  input  logic             sel_here,
  input  logic             sel_there,
  input  logic [WIDTH-1:0] in_there,
  input  logic [WIDTH-1:0] own_reg,
  input  logic [WIDTH-1:0] peer_reg,
  input  logic [WIDTH-1:0] hold_here,
  output logic [WIDTH-1:0] y
);
  live_src_e        src;
  logic [WIDTH-1:0] live;
  logic [WIDTH-1:0] muxed;

  always_comb begin
    if (!drv_there)     src = LIVE_PORT;
    else if (sel_there) src = LIVE_PEERREG;
    else                src = LIVE_HOLD;
  end

  always_comb begin
    unique case (src)
      LIVE_PORT:    live = in_there;
      LIVE_PEERREG: live = peer_reg;
      default:      live = hold_here;
    endcase
  end

  xcvr_gfmux #(.WIDTH(WIDTH)) u_mux (
    .sel    (sel_here),
    .live   (live),
    .stored (own_reg),
    .y      (muxed)
  );

  always_comb begin
    y = drv_here ? muxed : '0;
  end
endmodule

// File: rtl/bus_xcvr.sv
module bus_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ab_en,
  input  logic             ba_en_n,
  input  logic             ab_sel,
  input  logic             ba_sel,
  input  logic             cap_a,
  input  logic             cap_b,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic [WIDTH-1:0] reg_a, reg_b, hold_a, hold_b;
  logic [WIDTH-1:0] res_a, res_b;
  logic             drv_a, drv_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  assign drv_a = ~ba_en_n;
  assign drv_b = ab_en;

  xcvr_leg #(.WIDTH(WIDTH)) u_leg_ba (
    .drv_here  (drv_a),
    .drv_there (drv_b),
    .sel_here  (ba_sel),
    .sel_there (ab_sel),
    .in_there  (b_in),
    .own_reg   (reg_b),
    .peer_reg  (reg_a),
    .hold_here (hold_a),
    .y         (a_out)
  );

  xcvr_leg #(.WIDTH(WIDTH)) u_leg_ab (
    .drv_here  (drv_b),
    .drv_there (drv_a),
    .sel_here  (ab_sel),
    .sel_there (ba_sel),
    .in_there  (a_in),
    .own_reg   (reg_a),
    .peer_reg  (reg_b),
    .hold_here (hold_b),
    .y         (b_out)
  );

  assign a_oe  = drv_a;
  assign b_oe  = drv_b;
  assign res_a = drv_a ? a_out : a_in;
  assign res_b = drv_b ? b_out : b_in;

  xcvr_store #(.WIDTH(WIDTH)) u_reg_a (
    .clk(clk), .rst_n(rst_sync_n), .load(cap_a), .d(res_a), .q(reg_a));
  xcvr_store #(.WIDTH(WIDTH)) u_reg_b (
    .clk(clk), .rst_n(rst_sync_n), .load(cap_b), .d(res_b), .q(reg_b));
  xcvr_store #(.WIDTH(WIDTH)) u_hold_a (
    .clk(clk), .rst_n(rst_sync_n), .load(1'b1), .d(res_a), .q(hold_a));
  xcvr_store #(.WIDTH(WIDTH)) u_hold_b (
    .clk(clk), .rst_n(rst_sync_n), .load(1'b1), .d(res_b), .q(hold_b));

  a_r2_isolate: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!ab_en && ba_en_n) |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0));

  a_r4_stored_ab: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ab_en && ab_sel) |-> (b_out == reg_a));

  a_r5_cap_a: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_a |=> (reg_a == $past(res_a)));

  a_r6_cap_b: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cap_b |=> (reg_b == $past(res_b)));

  a_r11_hold_b: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cap_b |=> $stable(reg_b));

  a_r8_loop_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ab_en && !ba_en_n && !ab_sel && !ba_sel &&
     $past(ab_en) && !$past(ba_en_n) && !$past(ab_sel) && !$past(ba_sel))
    |-> ($stable(a_out) && $stable(b_out)));
endmodule

// File: tb/bus_xcvr_tb_top.sv
module bus_xcvr_tb_top;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ab_en, ba_en_n, ab_sel, ba_sel, cap_a, cap_b;
  logic [W-1:0] a_in, b_in, a_out, b_out;
  logic a_oe, b_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic [W-1:0] m_ra, m_rb, m_ha, m_hb;

  always #5 clk = ~clk;

  bus_xcvr #(.WIDTH(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ab_en(ab_en), .ba_en_n(ba_en_n),
    .ab_sel(ab_sel), .ba_sel(ba_sel), .cap_a(cap_a), .cap_b(cap_b),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe));

  task automatic check(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag, logic en_ab, logic en_ba_n, logic s_ab, logic s_ba,
                      logic c_a, logic c_b, logic [W-1:0] ai, logic [W-1:0] bi);
    logic         eoa, eob;
    logic [W-1:0] ea, eb, ra_v, rb_v;
    @(negedge clk);
    ab_en = en_ab; ba_en_n = en_ba_n; ab_sel = s_ab; ba_sel = s_ba;
    cap_a = c_a; cap_b = c_b; a_in = ai; b_in = bi;
    #1;
    eoa = !en_ba_n;
    eob = en_ab;
    if (eoa && eob && !s_ab && !s_ba) begin
      ea = m_ha; eb = m_hb;
    end else begin
      ea = !eoa ? '0 : s_ba ? m_rb : (!eob ? bi : m_ra);
      eb = !eob ? '0 : s_ab ? m_ra : (!eoa ? ai : m_rb);
    end
    check(tag, "a_oe", {{(W-1){1'b0}}, a_oe}, {{(W-1){1'b0}}, eoa});
    check(tag, "b_oe", {{(W-1){1'b0}}, b_oe}, {{(W-1){1'b0}}, eob});
    check(tag, "a_out", a_out, ea);
    check(tag, "b_out", b_out, eb);
    ra_v = eoa ? ea : ai;
    rb_v = eob ? eb : bi;
    if (c_a) m_ra = ra_v;
    if (c_b) m_rb = rb_v;
    m_ha = ra_v;
    m_hb = rb_v;
    @(posedge clk);
  endtask

  initial begin
    #1500000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ra = '0; m_rb = '0; m_ha = '0; m_hb = '0;
    rst_n = 1'b0;
    ab_en = 1'b0; ba_en_n = 1'b1; ab_sel = 1'b0; ba_sel = 1'b0;
    cap_a = 1'b0; cap_b = 1'b0; a_in = '0; b_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);

    // R10: registers cleared, shown through stored select both ways
    step("R10", 1, 0, 1, 1, 0, 0, 8'h00, 8'h00);
    // R2: isolation with busy inputs
    step("R2", 0, 1, 0, 0, 0, 0, 8'hA5, 8'h5A);
    step("R2", 0, 1, 1, 1, 0, 0, 8'hFF, 8'h01);
    // R3 and R1: live A to B, then live B to A
    step("R3", 1, 1, 0, 0, 0, 0, 8'h5A, 8'h00);
    step("R3", 0, 0, 0, 0, 0, 0, 8'h00, 8'h96);
    // R6: both captures together while isolated
    step("R6", 0, 1, 0, 0, 1, 1, 8'h3C, 8'hC3);
    // R4: stored data out both ways
    step("R4", 1, 0, 1, 1, 0, 0, 8'h00, 8'hFF);
    // R7: A live onto B, B register captures driven value not b_in
    step("R7", 1, 1, 0, 0, 0, 1, 8'h77, 8'h10);
    step("R7", 0, 0, 1, 1, 0, 0, 8'h00, 8'h00);
    // R5: capture regardless of select and enable settings
    step("R5", 1, 0, 1, 1, 1, 0, 8'h22, 8'h00);
    step("R5", 1, 1, 1, 0, 0, 0, 8'h00, 8'h00);
    // R11: no strobe, register unchanged despite port activity
    step("R11", 0, 1, 0, 0, 0, 0, 8'hEE, 8'hDD);
    step("R11", 1, 0, 1, 1, 0, 0, 8'h00, 8'h00);
    // R8: prime with A live onto B, then loop mode ignores inputs
    step("R8", 1, 1, 0, 0, 0, 0, 8'h11, 8'h00);
    for (int i = 0; i < 4; i++) step("R8", 1, 0, 0, 0, 0, 0, 8'hFF, 8'h00);
    step("R8", 1, 0, 0, 0, 1, 1, 8'h0F, 8'hF0);
    // R9: capture X into A register, toggle select with live equal to stored
    step("R9", 0, 1, 0, 0, 1, 0, 8'h6B, 8'h00);
    for (int i = 0; i < 6; i++) step("R9", 1, 1, i[0], 0, 0, 0, 8'h6B, 8'h00);

    // R1: random sweep across every enable and select combination
    for (int i = 0; i < 600; i++) begin
      logic [3:0] ctl;
      ctl = 4'(i);
      step("R1", ctl[0], ctl[1], ctl[2], ctl[3],
           1'($urandom), 1'($urandom), 8'($urandom), 8'($urandom));
    end

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule